// File: doc/BRIEF.md
# Low-Power Mode and Wake-Up Controller

This block is the mode sequencer of a supply-management chip. It holds the chip in one of five modes: Reset, Normal-Request, Normal, low power with the main supply off, and low power with the main supply kept on. It moves between them on mode words written over SPI, on a request from the fail-safe logic, and on wake events. The analog regulators, the bus transceivers and the SPI shifter are outside the block. It sees each of them as a single-cycle strobe or a level, and it drives the enable of each regulator.

While in either low-power mode the block watches the wake sources. These are a CAN wake, a LIN wake, a rising edge on selected I/O pins, a cyclic-sense change on I/O-1 gated by I/O-0, and the internal wake timer. With the main supply kept on, two more sources count: the SPI Normal-Request word and a main-supply overcurrent that lasts too long. Every source that fires sets its own sticky flag. Software clears the flags with one strobe. A wake with the supply off passes through Reset before Normal-Request. A wake with the supply on goes straight to Normal-Request and drives the active-low interrupt line low for a fixed time.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: While `rst_n` is low and for `RST_CYC` cycles after its release, `mode` is 0 (Reset). It then becomes 1 (Normal-Request). In this state `int_n` is 1, `wake_flags` is 0, `vdd_en` is 1, and `can5_en`, `vaux_en` and `pnp_en` are 0.
- R2: In Normal-Request, an SPI write of 16'h5A00 moves to `mode` 2 (Normal). In Normal-Request and Normal, `vdd_en`, `can5_en` and `vaux_en` are 1, and `pnp_en` follows `pnp_cfg`.
- R3: From Normal, `failsafe_req` or the word 16'h5C80 enters `mode` 3 (low power, supply off), and the word 16'h5CA0 enters `mode` 4 (low power, supply on). `failsafe_req` wins over a word in the same cycle. Every entry is refused while `wake_flags` is nonzero.
- R4: In mode 3, all four enables are 0. In mode 4, `vdd_en` is 1 and `can5_en`, `vaux_en` and `pnp_en` are 0.
- R5: In modes 3 and 4 the following are wake sources: `can_wake` (flag bit 0), `lin_wake` (bit 1), a rising edge on any I/O pin selected by `EDGE_MASK` (bit 2, default pins 2 and 3), and `timer_wake` (bit 4).
- R6: The cyclic-sense wake (flag bit 3) fires in modes 3 and 4 when `io_pin[0]` is high and `io_pin[1]` differs from the value it had in the last cycle before low power was entered.
- R7: Only in mode 4, an SPI write of 16'h5C10 is a wake (bit 5), and so is `vdd_oc` held high for `OC_US` microseconds of consecutive cycles (bit 6). In mode 3 both are ignored.
- R8: A wake in mode 3 moves to Reset on the next edge. Reset then lasts `RST_CYC` cycles before Normal-Request. No interrupt pulse is produced.
- R9: A wake in mode 4 moves to Normal-Request on the next edge. From that cycle `int_n` is 0 for `INT_US`·`CLK_MHZ` cycles. Sources that fire together all set their flags and produce one pulse.
- R10: Flags stay set until `spi_flag_clr`. A source that fires in the same cycle as the clear keeps its bit set.
- R11: Wake inputs have no effect on flags, mode or `int_n` outside modes 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_wr | input | 1 | Strobe: a mode word was written |
| spi_data | input | 16 | Mode word that goes with `spi_wr` |
| spi_flag_clr | input | 1 | Strobe: clear all wake flags |
| failsafe_req | input | 1 | Fail-safe request for low power with the supply off |
| can_wake | input | 1 | CAN transceiver wake strobe |
| lin_wake | input | 1 | LIN transceiver wake strobe |
| timer_wake | input | 1 | Internal wake timer expiry strobe |
| io_pin | input | NUM_IO | Synchronised I/O pin levels |
| vdd_oc | input | 1 | Main-supply load above the overcurrent threshold |
| pnp_cfg | input | 1 | External pass-transistor enable wanted in active modes |
| mode | output | 3 | Current mode code |
| vdd_en | output | 1 | Main regulator enable |
| can5_en | output | 1 | Transceiver regulator enable |
| vaux_en | output | 1 | Auxiliary regulator enable |
| pnp_en | output | 1 | External pass-transistor enable |
| int_n | output | 1 | Active-low wake interrupt |
| wake_flags | output | 7 | Sticky wake-source flags |

## Verification
The bench goes after the refusal of low-power entry while a flag is still set. A design that skipped that check would drop into low power with a stale wake pending and would never assert the interrupt for it. It fires several sources in one cycle to catch a design that kept only the highest-priority flag or produced more than one pulse. It drives the overcurrent input just below and just past the window, and it sends the SPI wake word and the overcurrent while the supply is off. A block that got these wrong would wake early or wake from the wrong mode. A clear that arrives in the same cycle as a new event must not erase that event.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [2:0] {
      MODE_RESET  = 3'd0,
      MODE_NREQ   = 3'd1,
      MODE_NORMAL = 3'd2,
      MODE_LP_OFF = 3'd3,
      MODE_LP_ON  = 3'd4
   } lpm_mode_e;

   localparam int FLAG_W = 7;
   localparam int FB_CAN = 0;
   localparam int FB_LIN = 1;
   localparam int FB_IO  = 2;
   localparam int FB_CYC = 3;
   localparam int FB_TMR = 4;
   localparam int FB_SPI = 5;
   localparam int FB_OC  = 6;
endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect
   import lpm_pkg::*;
#(
   parameter int                NUM_IO    = 4,
   parameter logic [NUM_IO-1:0] EDGE_MASK = 4'b1100,
   parameter int                OC_CYC    = 100
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp_off,
   input  logic              lp_on,
   input  logic              can_wake,
   input  logic              lin_wake,
   input  logic              timer_wake,
   input  logic [NUM_IO-1:0] io_pin,
   input  logic              spi_wake_cmd,
   input  logic              vdd_oc,
   output logic [FLAG_W-1:0] wake_evt
);
   logic              in_lp;
   logic [NUM_IO-1:0] rise;
   logic              ref1_q;
   logic              oc_hit;

   assign in_lp = lp_off | lp_on;

   for (genvar k = 0; k < NUM_IO; k++) begin : g_pin
      if (EDGE_MASK[k]) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= io_pin[k];
         end
         assign rise[k] = io_pin[k] & ~prev_q;
      end else begin : g_none
         assign rise[k] = 1'b0;
      end
   end

   // I/O-1 reference: frozen while low power is active
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ref1_q <= 1'b0;
      else if (!in_lp) ref1_q <= io_pin[1];
   end

   if (OC_CYC == 1) begin : g_oc_direct
      assign oc_hit = lp_on & vdd_oc;
   end else begin : g_oc_count
      localparam int              OCW     = $clog2(OC_CYC);
      localparam logic [OCW-1:0]  OC_LAST = OCW'(OC_CYC - 1);
      logic [OCW-1:0] oc_cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                oc_cnt_q <= '0;
         else if (lp_on && vdd_oc) begin
            if (oc_cnt_q != OC_LAST) oc_cnt_q <= oc_cnt_q + 1'b1;
         end else                   oc_cnt_q <= '0;
      end
      assign oc_hit = lp_on & vdd_oc & (oc_cnt_q == OC_LAST);

      assert_oc_sustained_R7: assert property (@(posedge clk) disable iff (!rst_n)
         oc_hit |-> $past(vdd_oc) && $past(lp_on));
   end

   always_comb begin
      wake_evt = '0;
      if (in_lp) begin
         wake_evt[FB_CAN] = can_wake;
         wake_evt[FB_LIN] = lin_wake;
         wake_evt[FB_IO]  = |rise;
         wake_evt[FB_CYC] = io_pin[0] & (io_pin[1] ^ ref1_q);
         wake_evt[FB_TMR] = timer_wake;
      end
      if (lp_on) begin
         wake_evt[FB_SPI] = spi_wake_cmd;
         wake_evt[FB_OC]  = oc_hit;
      end
   end
endmodule

// File: rtl/lpm_flag_bank.sv
module lpm_flag_bank #(
   parameter int W = 7
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic         clr,
   output logic [W-1:0] flags
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flags[i] <= 1'b0;
         else if (set_vec[i]) flags[i] <= 1'b1;
         else if (clr)        flags[i] <= 1'b0;
      end

      assert_flag_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
         set_vec[i] |=> flags[i]);
      assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !clr) |=> flags[i]);
   end
endmodule

// File: rtl/lpm_pulse_gen.sv
module lpm_pulse_gen #(
   parameter int LEN = 10000
)(
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic pulse_n
);
   localparam int             PW      = $clog2(LEN + 1);
   localparam logic [PW-1:0]  PULSE_L = PW'(LEN);

   logic [PW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (trig)       cnt_q <= PULSE_L;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign pulse_n = (cnt_q == '0);

   assert_pulse_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> !pulse_n);
endmodule

// File: rtl/lpm_mode_seq.sv
module lpm_mode_seq
   import lpm_pkg::*;
#(
   parameter int          RST_CYC    = 16,
   parameter logic [15:0] WORD_NREQ  = 16'h5C10,
   parameter logic [15:0] WORD_RUN   = 16'h5A00,
   parameter logic [15:0] WORD_LPOFF = 16'h5C80,
   parameter logic [15:0] WORD_LPON  = 16'h5CA0
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      spi_wr,
   input  logic [15:0] spi_data,
   input  logic      failsafe_req,
   input  logic      any_flag,
   input  logic      any_wake,
   input  logic      pnp_cfg,
   output lpm_mode_e mode_q,
   output logic      lp_off,
   output logic      lp_on,
   output logic      spi_wake_cmd,
   output logic      wake_on_trig,
   output logic      vdd_en,
   output logic      can5_en,
   output logic      vaux_en,
   output logic      pnp_en
);
   localparam int            RCW      = $clog2(RST_CYC + 1);
   localparam logic [RCW-1:0] RST_LAST = RCW'(RST_CYC - 1);

   lpm_mode_e      mode_d;
   logic [RCW-1:0] rst_cnt_q;
   logic           cmd_run, cmd_lpoff, cmd_lpon, active;

   assign cmd_run      = spi_wr && (spi_data == WORD_RUN);
   assign cmd_lpoff    = spi_wr && (spi_data == WORD_LPOFF);
   assign cmd_lpon     = spi_wr && (spi_data == WORD_LPON);
   assign spi_wake_cmd = spi_wr && (spi_data == WORD_NREQ);

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_RESET:  if (rst_cnt_q == RST_LAST) mode_d = MODE_NREQ;
         MODE_NREQ:   if (cmd_run) mode_d = MODE_NORMAL;
         MODE_NORMAL: if (!any_flag) begin
            if (failsafe_req)   mode_d = MODE_LP_OFF;
            else if (cmd_lpoff) mode_d = MODE_LP_OFF;
            else if (cmd_lpon)  mode_d = MODE_LP_ON;
         end
         MODE_LP_OFF: if (any_wake) mode_d = MODE_RESET;
         MODE_LP_ON:  if (any_wake) mode_d = MODE_NREQ;
         default:     mode_d = MODE_RESET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_RESET;
         rst_cnt_q <= '0;
      end else begin
         mode_q    <= mode_d;
         rst_cnt_q <= (mode_q == MODE_RESET && mode_d == MODE_RESET) ?
                      rst_cnt_q + 1'b1 : '0;
      end
   end

   assign lp_off       = (mode_q == MODE_LP_OFF);
   assign lp_on        = (mode_q == MODE_LP_ON);
   assign wake_on_trig = lp_on & any_wake;
   assign active       = (mode_q == MODE_NREQ) || (mode_q == MODE_NORMAL);
   assign vdd_en       = !lp_off;
   assign can5_en      = active;
   assign vaux_en      = active;
   assign pnp_en       = active & pnp_cfg;

   assert_reset_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_RESET && rst_cnt_q != RST_LAST) |=> mode_q == MODE_RESET);
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
   import lpm_pkg::*;
#(
   parameter int                NUM_IO     = 4,
   parameter logic [NUM_IO-1:0] EDGE_MASK  = 4'b1100,
   parameter int                CLK_MHZ    = 100,
   parameter int                INT_US     = 100,
   parameter int                OC_US      = 32000,
   parameter int                RST_CYC    = 16,
   parameter logic [15:0]       WORD_NREQ  = 16'h5C10,
   parameter logic [15:0]       WORD_RUN   = 16'h5A00,
   parameter logic [15:0]       WORD_LPOFF = 16'h5C80,
   parameter logic [15:0]       WORD_LPON  = 16'h5CA0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_wr,
   input  logic [15:0]       spi_data,
   input  logic              spi_flag_clr,
   input  logic              failsafe_req,
   input  logic              can_wake,
   input  logic              lin_wake,
   input  logic              timer_wake,
   input  logic [NUM_IO-1:0] io_pin,
   input  logic              vdd_oc,
   input  logic              pnp_cfg,
   output logic [2:0]        mode,
   output logic              vdd_en,
   output logic              can5_en,
   output logic              vaux_en,
   output logic              pnp_en,
   output logic              int_n,
   output logic [FLAG_W-1:0] wake_flags
);
   localparam int INT_CYC = INT_US * CLK_MHZ;
   localparam int OC_CYC  = OC_US * CLK_MHZ;

   if (NUM_IO < 2) begin : g_chk_io
      $error("NUM_IO must be at least 2: pins 0 and 1 drive cyclic sense");
   end
   if (EDGE_MASK[1:0] != 2'b00) begin : g_chk_mask
      $error("EDGE_MASK must leave pins 0 and 1 to cyclic sense");
   end
   if (INT_CYC < 1 || OC_CYC < 1 || RST_CYC < 1) begin : g_chk_time
      $error("timing parameters must give at least one cycle");
   end
   if (WORD_NREQ == WORD_RUN || WORD_NREQ == WORD_LPOFF || WORD_NREQ == WORD_LPON ||
       WORD_RUN == WORD_LPOFF || WORD_RUN == WORD_LPON || WORD_LPOFF == WORD_LPON)
   begin : g_chk_words
      $error("mode words must be distinct");
   end

   lpm_mode_e         mode_q;
   logic              lp_off, lp_on, spi_wake_cmd, wake_on_trig;
   logic [FLAG_W-1:0] wake_evt;

   lpm_mode_seq #(
      .RST_CYC(RST_CYC), .WORD_NREQ(WORD_NREQ), .WORD_RUN(WORD_RUN),
      .WORD_LPOFF(WORD_LPOFF), .WORD_LPON(WORD_LPON)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .spi_wr(spi_wr), .spi_data(spi_data),
      .failsafe_req(failsafe_req), .any_flag(|wake_flags), .any_wake(|wake_evt),
      .pnp_cfg(pnp_cfg), .mode_q(mode_q), .lp_off(lp_off), .lp_on(lp_on),
      .spi_wake_cmd(spi_wake_cmd), .wake_on_trig(wake_on_trig),
      .vdd_en(vdd_en), .can5_en(can5_en), .vaux_en(vaux_en), .pnp_en(pnp_en)
   );

   lpm_wake_detect #(
      .NUM_IO(NUM_IO), .EDGE_MASK(EDGE_MASK), .OC_CYC(OC_CYC)
   ) u_det (
      .clk(clk), .rst_n(rst_n), .lp_off(lp_off), .lp_on(lp_on),
      .can_wake(can_wake), .lin_wake(lin_wake), .timer_wake(timer_wake),
      .io_pin(io_pin), .spi_wake_cmd(spi_wake_cmd), .vdd_oc(vdd_oc),
      .wake_evt(wake_evt)
   );

   lpm_flag_bank #(.W(FLAG_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_vec(wake_evt), .clr(spi_flag_clr),
      .flags(wake_flags)
   );

   lpm_pulse_gen #(.LEN(INT_CYC)) u_int (
      .clk(clk), .rst_n(rst_n), .trig(wake_on_trig), .pulse_n(int_n)
   );

   assign mode = mode_q;

   assert_entry_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_NORMAL && |wake_flags) |=> mode_q == MODE_NORMAL);
   assert_off_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_LP_OFF && |wake_evt) |=> mode_q == MODE_RESET);
   assert_on_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_LP_ON && |wake_evt) |=> (mode_q == MODE_NREQ && !int_n));
   assert_int_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_n) |-> $past(mode_q) == MODE_LP_ON);
   assert_lp_supply_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_LP_OFF || mode_q == MODE_LP_ON) |-> !can5_en && !vaux_en && !pnp_en);
endmodule

// File: tb/tb_lpm_wake_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_wake_ctrl;
   localparam int T_INT = 100;
   localparam int T_OC  = 100;
   localparam int T_RST = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_wr = 1'b0;
   logic [15:0] spi_data = '0;
   logic        spi_flag_clr = 1'b0, failsafe_req = 1'b0;
   logic        can_wake = 1'b0, lin_wake = 1'b0, timer_wake = 1'b0;
   logic [3:0]  io_pin = '0;
   logic        vdd_oc = 1'b0, pnp_cfg = 1'b0;
   logic [2:0]  mode;
   logic        vdd_en, can5_en, vaux_en, pnp_en, int_n;
   logic [6:0]  wake_flags;

   lpm_wake_ctrl #(.CLK_MHZ(100), .INT_US(1), .OC_US(1), .RST_CYC(T_RST)) dut (
      .clk(clk), .rst_n(rst_n), .spi_wr(spi_wr), .spi_data(spi_data),
      .spi_flag_clr(spi_flag_clr), .failsafe_req(failsafe_req),
      .can_wake(can_wake), .lin_wake(lin_wake), .timer_wake(timer_wake),
      .io_pin(io_pin), .vdd_oc(vdd_oc), .pnp_cfg(pnp_cfg), .mode(mode),
      .vdd_en(vdd_en), .can5_en(can5_en), .vaux_en(vaux_en), .pnp_en(pnp_en),
      .int_n(int_n), .wake_flags(wake_flags)
   );

   always #5 clk = ~clk;

   int    n_vec = 0, n_bad = 0, n_cyc = 0;
   string cur_req = "R1";

   // behavioural reference
   int         m_mode = 0, m_rc = 0, m_ic = 0, m_oc = 0;
   logic [6:0] m_flags = '0;
   logic [3:0] m_prev = '0;
   logic       m_ref = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      logic [6:0] evt;
      int         nxt;
      bit         lp;
      if (!rst_n) begin
         m_mode = 0; m_rc = 0; m_ic = 0; m_oc = 0;
         m_flags = '0; m_prev = '0; m_ref = 1'b0;
      end else begin
         evt = '0;
         lp  = (m_mode == 3) || (m_mode == 4);
         if (lp) begin
            evt[0] = can_wake;
            evt[1] = lin_wake;
            evt[2] = |(io_pin & ~m_prev & 4'b1100);
            evt[3] = io_pin[0] && (io_pin[1] != m_ref);
            evt[4] = timer_wake;
         end
         if (m_mode == 4) begin
            evt[5] = spi_wr && (spi_data == 16'h5C10);
            evt[6] = vdd_oc && (m_oc == T_OC - 1);
         end
         nxt = m_mode;
         case (m_mode)
            0: if (m_rc == T_RST - 1) nxt = 1;
            1: if (spi_wr && spi_data == 16'h5A00) nxt = 2;
            2: if (m_flags == 0) begin
                  if (failsafe_req) nxt = 3;
                  else if (spi_wr && spi_data == 16'h5C80) nxt = 3;
                  else if (spi_wr && spi_data == 16'h5CA0) nxt = 4;
               end
            3: if (evt != 0) nxt = 0;
            4: if (evt != 0) nxt = 1;
            default: nxt = 0;
         endcase
         m_rc = (m_mode == 0 && nxt == 0) ? m_rc + 1 : 0;
         if (m_mode == 4 && evt != 0) m_ic = T_INT;
         else if (m_ic > 0)           m_ic = m_ic - 1;
         m_oc = (m_mode == 4 && vdd_oc) ? m_oc + 1 : 0;
         if (!lp) m_ref = io_pin[1];
         m_prev  = io_pin;
         m_flags = (spi_flag_clr ? 7'd0 : m_flags) | evt;
         m_mode  = nxt;
      end
   end

   task automatic cmp(input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
      end
   endtask

   // per-cycle comparison, sampled 3 ns after the active edge
   always begin
      bit act_mode;
      @(posedge clk);
      #3;
      act_mode = (m_mode == 1) || (m_mode == 2);
      cmp("mode", int'(mode), m_mode);
      cmp("vdd_en", int'(vdd_en), int'(m_mode != 3));
      cmp("can5_en", int'(can5_en), int'(act_mode));
      cmp("vaux_en", int'(vaux_en), int'(act_mode));
      cmp("pnp_en", int'(pnp_en), int'(act_mode && pnp_cfg));
      cmp("int_n", int'(int_n), int'(m_ic == 0));
      cmp("flags", int'(wake_flags), int'(m_flags));
   end

   always @(posedge clk) begin
      n_cyc++;
      if (n_cyc > 100000) begin
         n_bad++;
         $display("FAIL watchdog %s: actual=%0d expected=%0d", cur_req, n_cyc, 100000);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic spi(input logic [15:0] w);
      @(negedge clk); spi_wr = 1'b1; spi_data = w;
      @(negedge clk); spi_wr = 1'b0; spi_data = '0;
   endtask

   task automatic clr_flags;
      @(negedge clk); spi_flag_clr = 1'b1;
      @(negedge clk); spi_flag_clr = 1'b0;
   endtask

   initial begin
      // R1: reset state and exit to Normal-Request
      cyc(3);
      cmp("reset mode", int'(mode), 0);
      cmp("reset int_n", int'(int_n), 1);
      rst_n = 1'b1;
      cyc(T_RST + 3);
      cmp("after reset mode", int'(mode), 1);

      cur_req = "R2";
      pnp_cfg = 1'b1;
      spi(16'h5A00);
      cmp("normal mode", int'(mode), 2);
      cmp("normal pnp", int'(pnp_en), 1);

      cur_req = "R11";
      @(negedge clk); can_wake = 1'b1; lin_wake = 1'b1; io_pin = 4'b1111;
      @(negedge clk); can_wake = 1'b0; lin_wake = 1'b0; io_pin = 4'b0000;
      cyc(1);
      cmp("no flags outside lp", int'(wake_flags), 0);

      cur_req = "R4";
      spi(16'h5CA0);
      cmp("lp_on mode", int'(mode), 4);
      cmp("lp_on vdd", int'(vdd_en), 1);
      cmp("lp_on pnp", int'(pnp_en), 0);

      cur_req = "R9";
      @(negedge clk); can_wake = 1'b1; lin_wake = 1'b1; timer_wake = 1'b1;
      @(negedge clk); can_wake = 1'b0; lin_wake = 1'b0; timer_wake = 1'b0;
      cmp("multi-source flags", int'(wake_flags), 'h13);
      cmp("int low", int'(int_n), 0);
      cmp("to nreq", int'(mode), 1);
      cyc(T_INT + 5);
      cmp("int released", int'(int_n), 1);

      cur_req = "R3";
      spi(16'h5A00);
      spi(16'h5CA0);
      cmp("entry refused", int'(mode), 2);

      cur_req = "R10";
      clr_flags();
      cmp("flags cleared", int'(wake_flags), 0);

      cur_req = "R3";
      @(negedge clk); failsafe_req = 1'b1; spi_wr = 1'b1; spi_data = 16'h5CA0;
      @(negedge clk); failsafe_req = 1'b0; spi_wr = 1'b0; spi_data = '0;
      cmp("failsafe wins", int'(mode), 3);

      cur_req = "R7";
      spi(16'h5C10);
      @(negedge clk); vdd_oc = 1'b1;
      cyc(T_OC + 20);
      vdd_oc = 1'b0;
      cyc(2);
      cmp("lp_off ignores spi and oc", int'(mode), 3);

      cur_req = "R4";
      cmp("lp_off supplies", int'({vdd_en, can5_en, vaux_en, pnp_en}), 0);

      cur_req = "R6";
      @(negedge clk); io_pin[1] = 1'b1;
      cyc(3);
      cmp("cyclic idle without io0", int'(mode), 3);
      io_pin[0] = 1'b1;
      cyc(1);
      cmp("cyclic wake to reset", int'(mode), 0);
      cmp("cyclic flag", int'(wake_flags), 'h08);

      cur_req = "R8";
      cyc(T_RST + 3);
      cmp("reset then nreq", int'(mode), 1);
      cmp("no int from lp_off", int'(int_n), 1);
      io_pin = '0;

      cur_req = "R7";
      clr_flags();
      spi(16'h5A00);
      spi(16'h5CA0);
      @(negedge clk); vdd_oc = 1'b1;
      cyc(T_OC / 2);
      vdd_oc = 1'b0;
      cyc(2);
      cmp("short oc ignored", int'(mode), 4);
      spi(16'h5C10);
      cmp("spi wake", int'(wake_flags), 'h20);
      cyc(T_INT + 5);

      clr_flags();
      spi(16'h5A00);
      spi(16'h5CA0);
      @(negedge clk); vdd_oc = 1'b1;
      cyc(T_OC + 10);
      vdd_oc = 1'b0;
      cmp("oc wake", int'(wake_flags), 'h40);
      cyc(T_INT + 5);

      cur_req = "R5";
      clr_flags();
      spi(16'h5A00);
      spi(16'h5C80);
      @(negedge clk); io_pin[2] = 1'b1;
      @(negedge clk);
      cmp("io edge flag", int'(wake_flags), 'h04);
      cmp("io edge mode", int'(mode), 0);
      cyc(T_RST + 3);
      io_pin = '0;

      cur_req = "R10";
      clr_flags();
      spi(16'h5A00);
      spi(16'h5CA0);
      @(negedge clk); timer_wake = 1'b1; spi_flag_clr = 1'b1;
      @(negedge clk); timer_wake = 1'b0; spi_flag_clr = 1'b0;
      cmp("set beats clear", int'(wake_flags), 'h10);
      cyc(T_INT + 10);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule